// File: doc/BRIEF.md
# Conditional Trap Compare Evaluator

This block decides whether a compare-and-trap instruction fires. It compares two 64-bit operands in five ways at once: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. It packs the five results into a fixed-order relation vector and ANDs that vector with a 5-bit condition mask taken from the instruction. The trap fires when any masked relation holds. It also fires when the decoder has already flagged a trap kind on a nonzero 5-bit trap-kind vector, whatever the comparison says.

A word-mode flag narrows the operands before they are compared. For the signed relations, the low 32 bits of each operand are sign-extended. For the unsigned relations and equality, the low 32 bits are zero-extended. The logic is purely combinational, with no clock and no reset. A pipeline that needs a registered result places the flop outside this block. The relation vector is a port so that the comparison result can be observed directly.

Top module: `trap_cond_eval`

## Requirements
- R1: `rel_vec_o` bit positions are fixed: bit 0 is unsigned greater-than, bit 1 is unsigned less-than, bit 2 is equality, bit 3 is signed greater-than, bit 4 is signed less-than (A relative to B in every case).
- R2: With `word_mode_i` = 0, all five relations use the full 64-bit operands unchanged.
- R3: With `word_mode_i` = 1, the signed relations compare bits 31:0 of each operand, sign-extended from bit 31.
- R4: With `word_mode_i` = 1, the unsigned relations and equality compare bits 31:0 of each operand zero-extended. Bits 63:32 have no effect on any relation.
- R5: With `trap_kind_i` = 0, `take_trap_o` is 1 exactly when `rel_vec_o & cond_mask_i` is nonzero.
- R6: Any nonzero `trap_kind_i` forces `take_trap_o` to 1, regardless of operands and mask.
- R7: In each domain (signed and unsigned), exactly one of less-than, equal and greater-than holds. A mask of all ones (5'b11111) therefore always traps.
- R8: A zero mask together with a zero trap-kind vector never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 64 | First compare operand (A) |
| op_b_i | input | 64 | Second compare operand (B) |
| cond_mask_i | input | 5 | Condition mask, one bit per relation, same positions as `rel_vec_o` |
| word_mode_i | input | 1 | 1 = compare the low 32 bits only |
| trap_kind_i | input | 5 | Decoder-flagged trap kind; nonzero forces a trap |
| rel_vec_o | output | 5 | Packed relation vector |
| take_trap_o | output | 1 | Trap decision |

## Verification
Each directed pattern separates particular relations. Equal operands set only the equality bit. Operands that differ only in bit 63 make the signed and unsigned orderings disagree, which separates bit 4 from bit 0. Setting bit 31 in word mode gives the same split in the narrowed domain, and the same value in wide mode shows that both modes are honoured. Operands that differ only above bit 31 must compare equal in word mode and unequal in wide mode. Single-bit masks, a zero mask, an all-ones mask and forced trap kinds then map each relation onto the trap decision.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned REL_W    = 5;
    localparam int unsigned KIND_W   = 5;

    // MSB..LSB order is behaviour: bit4 slt, bit3 sgt, bit2 eq, bit1 ult, bit0 ugt
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

    typedef struct packed {
        logic [DATA_W-1:0] sa;
        logic [DATA_W-1:0] sb;
        logic [DATA_W-1:0] ua;
        logic [DATA_W-1:0] ub;
    } cmp_ops_t;

    function automatic logic [DATA_W-1:0] sext_word(input logic [DATA_W-1:0] v);
        return {{(DATA_W-WORD_W){v[WORD_W-1]}}, v[WORD_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] zext_word(input logic [DATA_W-1:0] v);
        return {{(DATA_W-WORD_W){1'b0}}, v[WORD_W-1:0]};
    endfunction

endpackage

// File: rtl/trap_operand_narrow.sv
module trap_operand_narrow
    import trap_cmp_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              word_mode_i,
    output cmp_ops_t          ops_o
);
    always_comb begin
        if (word_mode_i) begin
            ops_o.sa = sext_word(a_i);
            ops_o.sb = sext_word(b_i);
            ops_o.ua = zext_word(a_i);
            ops_o.ub = zext_word(b_i);
        end else begin
            ops_o.sa = a_i;
            ops_o.sb = b_i;
            ops_o.ua = a_i;
            ops_o.ub = b_i;
        end
    end

    // R4: narrowed unsigned operands carry nothing above the word
    always_comb begin
        if (word_mode_i) begin
            a_r4_upper_cleared: assert (ops_o.ua[DATA_W-1:WORD_W] == '0 &&
                                        ops_o.ub[DATA_W-1:WORD_W] == '0)
                else $error("R4 upper bits leaked");
        end
    end
endmodule

// File: rtl/trap_relation_unit.sv
module trap_relation_unit
    import trap_cmp_pkg::*;
(
    input  cmp_ops_t ops_i,
    output rel_t     rel_o
);
    always_comb begin
        rel_o.slt = $signed(ops_i.sa) <  $signed(ops_i.sb);
        rel_o.sgt = $signed(ops_i.sa) >  $signed(ops_i.sb);
        rel_o.ult = ops_i.ua < ops_i.ub;
        rel_o.ugt = ops_i.ua > ops_i.ub;
        rel_o.eq  = ops_i.ua == ops_i.ub;
    end

    // R7: trichotomy in each domain
    always_comb begin
        a_r7_unsigned_onehot: assert ($countones({rel_o.ult, rel_o.eq, rel_o.ugt}) == 1)
            else $error("R7 unsigned trichotomy broken");
        a_r7_signed_exclusive: assert ($onehot0({rel_o.slt, rel_o.sgt}))
            else $error("R7 signed lt and gt both set");
        if (rel_o.eq) begin
            a_r7_eq_no_signed_order: assert (!rel_o.slt && !rel_o.sgt)
                else $error("R7 equal yet signed-ordered");
        end
    end
endmodule

// File: rtl/trap_decide.sv
module trap_decide
    import trap_cmp_pkg::*;
(
    input  rel_t              rel_i,
    input  logic [REL_W-1:0]  mask_i,
    input  logic [KIND_W-1:0] kind_i,
    output logic              take_o
);
    logic cond_hit;

    always_comb begin
        cond_hit = |(rel_i & mask_i);
        take_o   = cond_hit | (|kind_i);
    end
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
    import trap_cmp_pkg::*;
(
    input  logic [63:0] op_a_i,
    input  logic [63:0] op_b_i,
    input  logic [4:0]  cond_mask_i,
    input  logic        word_mode_i,
    input  logic [4:0]  trap_kind_i,
    output logic [4:0]  rel_vec_o,
    output logic        take_trap_o
);
    cmp_ops_t ops;
    rel_t     rel;

    trap_operand_narrow u_narrow (
        .a_i        (op_a_i),
        .b_i        (op_b_i),
        .word_mode_i(word_mode_i),
        .ops_o      (ops)
    );

    trap_relation_unit u_rel (
        .ops_i(ops),
        .rel_o(rel)
    );

    trap_decide u_decide (
        .rel_i (rel),
        .mask_i(cond_mask_i),
        .kind_i(trap_kind_i),
        .take_o(take_trap_o)
    );

    assign rel_vec_o = rel;

    always_comb begin
        if (trap_kind_i != '0) begin
            a_r6_kind_forces: assert (take_trap_o)
                else $error("R6 forced kind did not trap");
        end
        if (cond_mask_i == '1) begin
            a_r7_full_mask_traps: assert (take_trap_o)
                else $error("R7 full mask did not trap");
        end
        if (cond_mask_i == '0 && trap_kind_i == '0) begin
            a_r8_silent: assert (!take_trap_o)
                else $error("R8 trap with nothing enabled");
        end
        if (word_mode_i && op_a_i[31:0] == op_b_i[31:0]) begin
            a_r4_word_equal: assert (rel_vec_o == 5'b00100)
                else $error("R4 equal words not equal");
        end
    end
endmodule

// File: tb/tb_trap_cond_eval.sv
module tb_trap_cond_eval;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [63:0] a, b;
    logic [4:0]  mask, kind, rel;
    logic        word, take;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    trap_cond_eval dut (
        .op_a_i(a), .op_b_i(b), .cond_mask_i(mask), .word_mode_i(word),
        .trap_kind_i(kind), .rel_vec_o(rel), .take_trap_o(take)
    );

    // reference from requirements R1..R4
    function automatic logic [4:0] model_rel(input logic [63:0] x, input logic [63:0] y,
                                             input logic w);
        logic signed [63:0] xs, ys;
        logic [63:0] xu, yu;
        if (w) begin
            xs = {{32{x[31]}}, x[31:0]}; ys = {{32{y[31]}}, y[31:0]};
            xu = {32'd0, x[31:0]};       yu = {32'd0, y[31:0]};
        end else begin
            xs = x; ys = y; xu = x; yu = y;
        end
        return {xs < ys, xs > ys, xu == yu, xu < yu, xu > yu};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic w,
                         input logic [4:0] m, input logic [4:0] k);
        @(negedge clk);
        a = x; b = y; word = w; mask = m; kind = k;
        #1;
    endtask

    task automatic chk_all(input string req);
        logic [4:0] er;
        er = model_rel(a, b, word);
        check(req, rel, er);
        check(req, take, (|(er & mask)) | (|kind));
    endtask

    task automatic t_idle;
        apply(0, 0, 0, 0, 0);
        check("R1 idle rel", rel, 5'b00100);
        check("R8 idle take", take, 0);
    endtask

    task automatic t_equal;
        apply(64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 0, 5'b00100, 0);
        check("R1 equal rel", rel, 5'b00100);
        check("R5 eq mask take", take, 1);
        apply(64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 0, 5'b11011, 0);
        check("R5 eq masked off", take, 0);
    endtask

    task automatic t_sign64;
        apply(64'h8000_0000_0000_0000, 64'h0, 0, 5'b10000, 0);
        check("R2 sign64 rel", rel, 5'b10001);
        check("R5 slt take", take, 1);
        apply(64'h8000_0000_0000_0000, 64'h0, 0, 5'b00010, 0);
        check("R5 ult miss", take, 0);
    endtask

    task automatic t_sign32;
        apply(64'h0000_0000_8000_0000, 64'h0, 1, 5'b10000, 0);
        check("R3 sign32 rel", rel, 5'b10001);
        check("R3 sign32 take", take, 1);
        apply(64'h0000_0000_8000_0000, 64'h0, 0, 5'b10000, 0);
        check("R2 same value wide", rel, 5'b01001);
        check("R2 wide no slt", take, 0);
    endtask

    task automatic t_upper;
        apply(64'hFFFF_0001_0000_0005, 64'h0000_0000_0000_0005, 1, 5'b11011, 0);
        check("R4 upper ignored rel", rel, 5'b00100);
        check("R4 upper ignored take", take, 0);
        apply(64'hFFFF_0001_0000_0005, 64'h0000_0000_0000_0005, 0, 5'b11011, 0);
        check("R2 upper counts", rel, 5'b10001);
    endtask

    task automatic t_kind_and_masks;
        apply(64'd3, 64'd3, 0, 5'b00000, 5'b00010);
        check("R6 forced kind", take, 1);
        apply(64'd3, 64'd9, 1, 5'b00000, 5'b10000);
        check("R6 forced kind word", take, 1);
        apply(64'd3, 64'd9, 0, 5'b00000, 0);
        check("R8 zero mask", take, 0);
        apply(64'd3, 64'd9, 0, 5'b11111, 0);
        check("R7 full mask", take, 1);
    endtask

    task automatic t_sweep;
        logic [63:0] pat [8];
        pat[0] = 64'h0;                   pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pat[2] = 64'h7FFF_FFFF_FFFF_FFFF; pat[3] = 64'h8000_0000_0000_0000;
        pat[4] = 64'h0000_0000_7FFF_FFFF; pat[5] = 64'h0000_0000_8000_0000;
        pat[6] = 64'h1234_0000_FFFF_FFFF; pat[7] = 64'h0000_0001_0000_0000;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int w = 0; w < 2; w++) begin
                    apply(pat[i], pat[j], w[0], 5'(1 << ((i + j) % 5)), 0);
                    chk_all("R1 R5 sweep");
                    mask = 5'b11111; #1;
                    check("R7 sweep full mask", take, 1);
                end
    endtask

    initial begin
        a = 0; b = 0; word = 0; mask = 0; kind = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle;
        t_equal;
        t_sign64;
        t_sign32;
        t_upper;
        t_kind_and_masks;
        t_sweep;
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule